// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks through the elements of one vector operation. It keeps two element counters, one for the source and one for the destination, and each counter has its own optional predicate mask. Each source element is a 64-bit register. The block reads it from a register file, sign-extends its lowest byte to the full width, and writes the result to a destination register. Because the counters move independently past masked-off elements, a source mask packs the selected inputs into consecutive outputs (compress). A destination mask spreads consecutive inputs across the selected outputs (expand). When both masks are active, both effects apply together.

A single `start` pulse captures the following inputs: both base register numbers, the requested length, the length ceiling, both masks and both mask-enable flags. The block reads through a combinational read port: it presents `rd_addr` and takes `rd_data` in the same cycle. It writes through a valid/ready port. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the pending write holds: its address, its data and its source address stay fixed, and neither counter moves. `done` pulses once when the walk ends.

Top module: `tpred_seq`

## Requirements
- R1: Each written value is the low 8 bits of the source register, sign-extended to 64 bits (0x90 gives 0xFFFF_FFFF_FFFF_FF90, 0x7F gives 0x7F). Bits 63..8 of the source have no effect.
- R2: With neither mask enabled, element i is read from register (src_base+i) mod 32 and written to register (dst_base+i) mod 32, in increasing i order.
- R3: With the source mask enabled, a source element whose mask bit is 0 is never read into a result. Each enabled source element pairs with the next destination element, so the outputs are packed.
- R4: With the destination mask enabled, a destination element whose mask bit is 0 is not written and keeps its previous contents. Consecutive source elements fill the enabled destination slots.
- R5: Mask bit i governs element i, with bit 0 as element 0. The walk ends as soon as either counter reaches the effective length, and all later destination registers stay unwritten.
- R6: The effective length is vl when vl <= maxvl, and maxvl otherwise.
- R7: Without back-pressure, each busy cycle does exactly one of two things. Either it issues one write and advances both counters, or it issues no write and advances each masked-off side by one. `done` is high on cycle N+1 after the start edge, where N is the number of such steps.
- R8: An effective length of 0 produces no write, and `done` is high in the first cycle after the start edge.
- R9: `done` lasts exactly one cycle. A `start` that arrives while `busy` is high has no effect on the run in progress and starts no new run.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `rd_addr` hold, and no element is lost or repeated.
- R11: After reset, `busy`, `done` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Start pulse; captures all run parameters |
| src_base | input | 5 | First source register |
| dst_base | input | 5 | First destination register |
| vl | input | 7 | Requested element count |
| maxvl | input | 7 | Ceiling on the element count |
| src_pred_en | input | 1 | Enable source masking |
| src_mask | input | 128 | Source mask, bit i for element i |
| dst_pred_en | input | 1 | Enable destination masking |
| dst_mask | input | 128 | Destination mask, bit i for element i |
| rd_addr | output | 5 | Register file read address |
| rd_data | input | 64 | Register file read data, same cycle |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Register file accepts the write |
| wr_addr | output | 5 | Write address |
| wr_data | output | 64 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench runs the compress and expand cases with a three-element vector and a 0b101 mask. A design that paired by a shared counter would write the skipped value or overwrite the hole. Other runs combine both masks, use a length above the ceiling, a zero length, a source mask with every bit clear, and register numbers that wrap past 31. An error here would show up as a write out of order, a write the scoreboard did not expect, or a wrong final register file. A fixed step count checks `done` timing, so a design that stalled on skip cycles or merged two skips would finish on the wrong cycle. Irregular `wr_ready` stalls and a second `start` during a run catch dropped or duplicated elements and parameters overwritten mid-run.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
  localparam int unsigned TPS_SIDES = 2;
endpackage

// File: rtl/tps_mask_pick.sv
module tps_mask_pick #(
  parameter int unsigned VL_W = 7
) (
  input  logic [(1<<VL_W)-1:0] mask,
  input  logic [VL_W-1:0]      idx,
  input  logic                 en,
  output logic                 ok
);
  // element is live when masking is off or its bit is set
  assign ok = !en || mask[idx];
endmodule

// File: rtl/tps_elem_op.sv
module tps_elem_op #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] res
);
  generate
    if (ELEM_W < DATA_W) begin : g_ext
      logic unused_hi;
      assign unused_hi = ^src[DATA_W-1:ELEM_W];
      assign res = {{(DATA_W-ELEM_W){src[ELEM_W-1]}}, src[ELEM_W-1:0]};
    end else begin : g_pass
      assign res = src;
    end
  endgenerate
endmodule

// File: rtl/tpred_seq.sv
module tpred_seq
  import tps_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned VL_W   = 7,
  parameter int unsigned RF_AW  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [RF_AW-1:0]        src_base,
  input  logic [RF_AW-1:0]        dst_base,
  input  logic [VL_W-1:0]         vl,
  input  logic [VL_W-1:0]         maxvl,
  input  logic                    src_pred_en,
  input  logic [(1<<VL_W)-1:0]    src_mask,
  input  logic                    dst_pred_en,
  input  logic [(1<<VL_W)-1:0]    dst_mask,
  output logic [RF_AW-1:0]        rd_addr,
  input  logic [DATA_W-1:0]       rd_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [RF_AW-1:0]        wr_addr,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    busy,
  output logic                    done
);
  localparam int unsigned MASK_W = 1 << VL_W;

  seq_state_e           state_q;
  logic [VL_W-1:0]      sidx_q, didx_q, len_q;
  logic [RF_AW-1:0]     sbase_q, dbase_q;
  logic                 spen_q, dpen_q;
  logic [MASK_W-1:0]    smask_q, dmask_q;
  logic [VL_W-1:0]      eff_len;
  logic                 run, at_end, s_ok, d_ok, pair;

  // side 0 = source, side 1 = destination
  logic [TPS_SIDES-1:0][MASK_W-1:0] side_mask;
  logic [TPS_SIDES-1:0][VL_W-1:0]   side_idx;
  logic [TPS_SIDES-1:0]             side_en, side_ok;

  assign side_mask = {dmask_q, smask_q};
  assign side_idx  = {didx_q, sidx_q};
  assign side_en   = {dpen_q, spen_q};

  generate
    for (genvar g = 0; g < TPS_SIDES; g++) begin : g_side
      tps_mask_pick #(.VL_W(VL_W)) u_pick (
        .mask (side_mask[g]),
        .idx  (side_idx[g]),
        .en   (side_en[g]),
        .ok   (side_ok[g])
      );
    end
  endgenerate

  assign s_ok    = side_ok[0];
  assign d_ok    = side_ok[1];
  assign eff_len = (vl > maxvl) ? maxvl : vl;
  assign run     = (state_q == SEQ_RUN);
  assign at_end  = (sidx_q >= len_q) || (didx_q >= len_q);
  assign pair    = run && !at_end && s_ok && d_ok;
  assign busy    = run;
  assign done    = run && at_end;

  assign rd_addr  = sbase_q + RF_AW'(sidx_q);
  assign wr_addr  = dbase_q + RF_AW'(didx_q);
  assign wr_valid = pair;

  tps_elem_op #(.DATA_W(DATA_W), .ELEM_W(ELEM_W)) u_op (
    .src (rd_data),
    .res (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      sidx_q  <= '0;
      didx_q  <= '0;
      len_q   <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      spen_q  <= 1'b0;
      dpen_q  <= 1'b0;
      smask_q <= '0;
      dmask_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            sidx_q  <= '0;
            didx_q  <= '0;
            len_q   <= eff_len;
            sbase_q <= src_base;
            dbase_q <= dst_base;
            spen_q  <= src_pred_en;
            dpen_q  <= dst_pred_en;
            smask_q <= src_mask;
            dmask_q <= dst_mask;
          end
        end
        default: begin
          if (at_end) begin
            state_q <= SEQ_IDLE;
          end else if (pair) begin
            if (wr_ready) begin
              sidx_q <= sidx_q + 1'b1;
              didx_q <= didx_q + 1'b1;
            end
          end else begin
            if (!s_ok) sidx_q <= sidx_q + 1'b1;
            if (!d_ok) didx_q <= didx_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(len_q) && $stable(dbase_q) && $stable(sbase_q))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !done)); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(rd_addr))); // R10

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end) |=> (((sidx_q - $past(sidx_q)) <= VL_W'(1)) &&
                          ((didx_q - $past(didx_q)) <= VL_W'(1)))); // R7

  AST_LEN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (len_q <= $past(maxvl))); // R6
endmodule

// File: tb/sim_tpred_seq.sv
module sim_tpred_seq;
  typedef struct packed {
    logic [4:0]  a;
    logic [63:0] d;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] src_base = '0, dst_base = '0;
  logic [6:0] vl = '0, maxvl = '0;
  logic src_pred_en = 1'b0, dst_pred_en = 1'b0;
  logic [127:0] src_mask = '0, dst_mask = '0;
  logic [4:0] rd_addr, wr_addr;
  logic [63:0] rd_data, wr_data;
  logic wr_valid, busy, done;
  logic wr_ready = 1'b1;

  logic [63:0] rf [32];
  logic [63:0] rf_model [32];
  wr_item_t exp_q[$];
  int checks = 0, fails = 0;
  bit bp_mode = 1'b0;
  int bp_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tpred_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base), .vl(vl), .maxvl(maxvl),
    .src_pred_en(src_pred_en), .src_mask(src_mask),
    .dst_pred_en(dst_pred_en), .dst_mask(dst_mask),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  assign rd_data = rf[rd_addr];

  always @(posedge clk) if (rst_n && wr_valid && wr_ready) rf[wr_addr] <= wr_data;

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    wr_ready = !bp_mode || ((bp_cnt % 5) >= 2);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R3/R4 unexpected write", {59'd0, wr_addr}, 64'd0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        chk(wr_addr == it.a, "R2/R3/R4 write address", {59'd0, wr_addr}, {59'd0, it.a});
        chk(wr_data == it.d, "R1 write data", wr_data, it.d);
      end
    end
  end

  function automatic logic [63:0] sx(input logic [63:0] v);
    return {{56{v[7]}}, v[7:0]};
  endfunction

  task automatic init_rf(input int seed);
    for (int i = 0; i < 32; i++) begin
      rf[i] = {24'hC0FFEE, 8'(i), 24'h0, 8'(seed * 7 + i * 29)};
      rf_model[i] = rf[i];
    end
  endtask

  task automatic set_reg(input int r, input logic [63:0] v);
    rf[r] = v;
    rf_model[r] = v;
  endtask

  task automatic run_case(input int sb, input int db, input int vl_i, input int mvl_i,
                          input bit spe, input logic [127:0] sm,
                          input bit dpe, input logic [127:0] dm,
                          input bit bp, input bit restart, input string tag);
    int len, s, d, iters, cyc, bad;
    bit so, dk;
    wr_item_t it;
    len = (vl_i > mvl_i) ? mvl_i : vl_i;   // R6
    s = 0; d = 0; iters = 0;
    while (s < len && d < len) begin
      iters++;
      so = !spe || sm[s];
      dk = !dpe || dm[d];
      if (so && dk) begin
        it.a = 5'((db + d) % 32);
        it.d = sx(rf_model[(sb + s) % 32]);
        rf_model[it.a] = it.d;
        exp_q.push_back(it);
        s++; d++;
      end else begin
        if (!so) s++;
        if (!dk) d++;
      end
    end
    bp_mode = bp;
    @(negedge clk);
    src_base = 5'(sb); dst_base = 5'(db); vl = 7'(vl_i); maxvl = 7'(mvl_i);
    src_pred_en = spe; src_mask = sm; dst_pred_en = dpe; dst_mask = dm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      if (restart && cyc == 2) begin
        start = 1'b1; vl = 7'd9; maxvl = 7'd9; dst_base = 5'(db + 11); src_pred_en = 1'b0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc < 2000, {tag, " R7 run finished"}, 64'(cyc), 64'd0);
    if (!bp) chk(cyc == iters + 1, {tag, " R7/R8 done cycle"}, 64'(cyc), 64'(iters + 1));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R9 done single pulse"}, {63'd0, done}, 64'd0);
    chk(exp_q.size() == 0, {tag, " R5 writes missing"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== rf_model[i]) bad++;
    chk(bad == 0, {tag, " R4/R5 register file contents"}, 64'(bad), 64'd0);
    repeat (2) @(negedge clk);
    bp_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    init_rf(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy after reset", {63'd0, busy}, 64'd0);
    chk(done == 1'b0, "R11 done after reset", {63'd0, done}, 64'd0);
    chk(wr_valid == 1'b0, "R11 wr_valid after reset", {63'd0, wr_valid}, 64'd0);

    // R1 R2: plain walk, mixed sign bytes
    init_rf(3);
    set_reg(2, 64'h1234_5678_9ABC_DE7F);
    run_case(0, 16, 8, 8, 0, '0, 0, '0, 0, 0, "plain");
    chk(rf[18] == 64'h0000_0000_0000_007F, "R1 positive byte", rf[18], 64'h7F);

    // R3: source compress, 0b101, VL=3
    init_rf(5);
    set_reg(9, 64'h90); set_reg(10, 64'h91); set_reg(11, 64'h92);
    set_reg(5, 64'h5555); set_reg(6, 64'h6666); set_reg(7, 64'h7777);
    run_case(9, 5, 3, 3, 1, 128'b101, 0, '0, 0, 0, "compress");
    chk(rf[5] == 64'hFFFF_FFFF_FFFF_FF90, "R3 first packed", rf[5], 64'hFFFF_FFFF_FFFF_FF90);
    chk(rf[6] == 64'hFFFF_FFFF_FFFF_FF92, "R3 second packed", rf[6], 64'hFFFF_FFFF_FFFF_FF92);
    chk(rf[7] == 64'h7777, "R5 trailing dest untouched", rf[7], 64'h7777);

    // R4: destination expand, 0b101, VL=3
    init_rf(6);
    set_reg(9, 64'h90); set_reg(10, 64'h91); set_reg(11, 64'h92);
    set_reg(5, 64'h5555); set_reg(6, 64'h6666); set_reg(7, 64'h7777);
    run_case(9, 5, 3, 3, 0, '0, 1, 128'b101, 0, 0, "expand");
    chk(rf[5] == 64'hFFFF_FFFF_FFFF_FF90, "R4 slot 0", rf[5], 64'hFFFF_FFFF_FFFF_FF90);
    chk(rf[6] == 64'h6666, "R4 masked slot kept", rf[6], 64'h6666);
    chk(rf[7] == 64'hFFFF_FFFF_FFFF_FF91, "R4 slot 2", rf[7], 64'hFFFF_FFFF_FFFF_FF91);

    // R3 R4 R5: both masks
    init_rf(7);
    run_case(2, 18, 10, 12, 1, 128'b11_0110_0101, 1, 128'b01_1011_1011, 0, 0, "twin");

    // R8: zero length
    init_rf(8);
    run_case(4, 20, 0, 5, 0, '0, 0, '0, 0, 0, "zero_len");

    // R6: length above ceiling
    init_rf(9);
    run_case(1, 12, 20, 6, 0, '0, 0, '0, 0, 0, "ceiling");

    // R7: all source bits clear, skip cycles only
    init_rf(10);
    run_case(0, 8, 6, 6, 1, '0, 0, '0, 0, 0, "all_skip");

    // R2: wraparound register numbers
    init_rf(11);
    run_case(28, 30, 6, 6, 0, '0, 0, '0, 0, 0, "wrap");

    // R10: back-pressure with masks
    init_rf(12);
    run_case(3, 17, 12, 12, 1, 128'b1011_0111_1101, 1, 128'b1110_1101_1111, 1, 0, "stall");

    // R9: start while busy ignored
    init_rf(13);
    run_case(0, 10, 7, 7, 0, '0, 0, '0, 0, 1, "restart");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule